// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block recovers data words from a single asynchronous serial line whose idle level is high. It runs on a sampling clock that is a whole multiple of the bit rate; the caller supplies that multiple as a clocks-per-bit value. Once a falling edge marks the start of a frame, the block samples every bit at its centre. It assembles a data word of 5 to 9 bits, checks the optional parity bit and the single stop bit, and then returns to idle.

Data width, parity mode, bit order and clocks-per-bit are read from their inputs on the start edge and held until the frame ends. The line-inversion control is applied continuously, ahead of the synchronizer. Each finished frame gives a one-cycle strobe. The strobe carries the word together with three error flags: bad start bit, parity mismatch and missing stop bit.

Top module: `serial_rx`

## Requirements
- R1: After reset the line must be seen high at least once before a falling edge counts as a frame start. A line held low through and after reset produces no strobe.
- R2: A frame begins when the synchronized line falls while the block is idle. The synchronizer has two stages. With `H = clks_per_bit >> 1` and bit index `k` (0 = start, 1..N = data, then parity if enabled, then stop), bit `k` is sampled `H + k*clks_per_bit` cycles after the edge cycle. The strobe is visible exactly `3 + H + K*clks_per_bit` clock edges after the line is driven low, where `K` is the stop-bit index.
- R3: In LSB-first order (`cfg_msb_first = 0`), the first data bit on the wire lands in `rx_data[0]`. For every width N from 5 to 9, bits at positions N and above read 0.
- R4: In MSB-first order (`cfg_msb_first = 1`), the first data bit on the wire lands in `rx_data[N-1]`.
- R5: Parity code 1 (odd) requires an odd count of ones across the data and parity bits. Code 2 (even) requires an even count. A mismatch sets `rx_parity_err`.
- R6: Parity code 3 requires the parity bit to be 0, and code 4 requires it to be 1. Any other parity-bit value sets `rx_parity_err`.
- R7: Parity code 0 (none) places the stop bit directly after the last data bit, and `rx_parity_err` is always 0.
- R8: A start bit that reads 1 at its centre sets `rx_start_err`, but the frame is still received to its end with data intact.
- R9: A stop bit that reads 0 sets `rx_frame_err`. The block then returns to idle and receives the next frame normally once the line has been high.
- R10: With `cfg_invert = 1` the line is complemented before synchronization, so a line that idles low with inverted bits decodes the same data.
- R11: `rx_valid` is high for exactly one cycle per frame.
- R12: Changing width, parity mode, order or clocks-per-bit after a frame has started does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input |
| cfg_invert | input | 1 | Complement the line before use |
| cfg_clks_per_bit | input | CPB_W | Sampling clocks per bit, at least 4 |
| cfg_width | input | WID_W | Data bits per frame, 5 to 9 |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 forced zero, 4 forced one |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| rx_data | output | MAX_WIDTH | Received word, zero-extended |
| rx_parity_err | output | 1 | Parity check failed |
| rx_frame_err | output | 1 | Stop bit read as 0 |
| rx_start_err | output | 1 | Start bit read as 1 at its centre |

## Verification
The embedded assertions hold on every cycle for several properties:
- the strobe is a single-cycle pulse;
- the word never carries bits above the latched width;
- the parity flag stays low in no-parity mode;
- the bit timer never reaches the latched bit period;
- an idle receiver leaves idle only on a falling edge;
- the latched configuration stays frozen while a frame is in progress.

Only the bench scenarios can show that the sample points fall where R2 places them, that the bits land in the right order and that the parity verdicts are correct. The bench does this by sweeping every width, parity mode and order with good and corrupted parity bits. It also covers a glitched start, a missing stop bit, an inverted line, a mid-frame configuration change and a line held low out of reset.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_front.sv
module serial_rx_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic invert_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Reset to low so that a line low at reset is never seen as a falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i ^ invert_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity
  import serial_rx_pkg::*;
#(
  parameter int MAX_WIDTH = 9,
  parameter int WID_W     = $clog2(MAX_WIDTH + 1)
) (
  input  logic [MAX_WIDTH-1:0] word_i,
  input  logic [WID_W-1:0]     width_i,
  input  par_mode_e            mode_i,
  input  logic                 pbit_i,
  output logic                 ok_o
);
  logic [MAX_WIDTH-1:0] mask;
  logic                 ones_odd;

  for (genvar i = 0; i < MAX_WIDTH; i++) begin : g_mask
    assign mask[i] = (WID_W'(i) < width_i);
  end

  assign ones_odd = ^(word_i & mask) ^ pbit_i;

  always_comb begin
    unique case (mode_i)
      PAR_ODD:  ok_o = ones_odd;
      PAR_EVEN: ok_o = ~ones_odd;
      PAR_ZERO: ok_o = ~pbit_i;
      PAR_ONE:  ok_o = pbit_i;
      default:  ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int CPB_W     = 16,
  parameter int MAX_WIDTH = 9,
  parameter int WID_W     = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 level_i,
  input  logic                 fall_i,
  input  logic [CPB_W-1:0]     cpb_i,
  input  logic [WID_W-1:0]     width_i,
  input  par_mode_e            mode_i,
  input  logic                 msb_first_i,
  output logic                 valid_o,
  output logic [MAX_WIDTH-1:0] data_o,
  output logic                 perr_o,
  output logic                 ferr_o,
  output logic                 serr_o
);
  rx_state_e            state;
  logic [CPB_W-1:0]     tmr;
  logic [CPB_W-1:0]     cpb_q;
  logic [WID_W-1:0]     width_q;
  logic [WID_W-1:0]     bit_idx;
  par_mode_e            mode_q;
  logic                 msb_q;
  logic [MAX_WIDTH-1:0] word;
  logic [MAX_WIDTH-1:0] word_next;
  logic                 serr_acc;
  logic                 perr_acc;
  logic                 par_ok;
  logic                 tick;

  assign tick = (tmr == '0);

  // Next word: LSB-first inserts at position width-1 after a right shift,
  // MSB-first shifts left and inserts at position 0.
  always_comb begin
    if (msb_q) begin
      word_next = {word[MAX_WIDTH-2:0], level_i};
    end else begin
      word_next = word >> 1;
      for (int i = 0; i < MAX_WIDTH; i++) begin
        if (WID_W'(i) == width_q - WID_W'(1)) word_next[i] = level_i;
      end
    end
  end

  serial_rx_parity #(
    .MAX_WIDTH(MAX_WIDTH),
    .WID_W    (WID_W)
  ) parity_i (
    .word_i (word),
    .width_i(width_q),
    .mode_i (mode_q),
    .pbit_i (level_i),
    .ok_o   (par_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      cpb_q    <= '0;
      width_q  <= '0;
      bit_idx  <= '0;
      mode_q   <= PAR_NONE;
      msb_q    <= 1'b0;
      word     <= '0;
      serr_acc <= 1'b0;
      perr_acc <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
      serr_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (state == ST_IDLE) begin
        if (fall_i) begin
          state    <= ST_START;
          tmr      <= (cpb_i >> 1) - CPB_W'(1);
          cpb_q    <= cpb_i;
          width_q  <= width_i;
          mode_q   <= mode_i;
          msb_q    <= msb_first_i;
          bit_idx  <= '0;
          word     <= '0;
          perr_acc <= 1'b0;
          serr_acc <= 1'b0;
        end
      end else if (!tick) begin
        tmr <= tmr - CPB_W'(1);
      end else begin
        tmr <= cpb_q - CPB_W'(1);
        unique case (state)
          ST_START: begin
            serr_acc <= level_i;
            state    <= ST_DATA;
          end
          ST_DATA: begin
            word <= word_next;
            if (bit_idx == width_q - WID_W'(1)) begin
              state <= (mode_q == PAR_NONE) ? ST_STOP : ST_PAR;
            end else begin
              bit_idx <= bit_idx + WID_W'(1);
            end
          end
          ST_PAR: begin
            perr_acc <= ~par_ok;
            state    <= ST_STOP;
          end
          ST_STOP: begin
            valid_o <= 1'b1;
            data_o  <= word;
            perr_o  <= perr_acc;
            ferr_o  <= ~level_i;
            serr_o  <= serr_acc;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: strobe lasts a single cycle
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7: no parity error is ever reported without parity
  assert_none_no_perr_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && mode_q == PAR_NONE) |-> !perr_o);

  // R3: nothing above the latched width
  assert_word_fits_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((data_o >> width_q) == '0));

  // R2: bit timer stays inside one bit period
  assert_timer_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (tmr < cpb_q));

  // R1: idle is left only on a falling edge
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !fall_i) |=> (state == ST_IDLE));

  // R12: frame settings frozen while a frame is in progress
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(width_q) && $stable(cpb_q) && $stable(msb_q)));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int CPB_W       = 16,
  parameter int MAX_WIDTH   = 9,
  parameter int SYNC_STAGES = 2,
  parameter int WID_W       = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic                 cfg_invert,
  input  logic [CPB_W-1:0]     cfg_clks_per_bit,
  input  logic [WID_W-1:0]     cfg_width,
  input  logic [2:0]           cfg_parity,
  input  logic                 cfg_msb_first,
  output logic                 rx_valid,
  output logic [MAX_WIDTH-1:0] rx_data,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err,
  output logic                 rx_start_err
);
  logic level;
  logic fall;

  serial_rx_front #(
    .STAGES(SYNC_STAGES)
  ) front_i (
    .clk     (clk),
    .rst     (rst),
    .line_i  (rx_line),
    .invert_i(cfg_invert),
    .level_o (level),
    .fall_o  (fall)
  );

  serial_rx_core #(
    .CPB_W    (CPB_W),
    .MAX_WIDTH(MAX_WIDTH),
    .WID_W    (WID_W)
  ) core_i (
    .clk        (clk),
    .rst        (rst),
    .level_i    (level),
    .fall_i     (fall),
    .cpb_i      (cfg_clks_per_bit),
    .width_i    (cfg_width),
    .mode_i     (par_mode_e'(cfg_parity)),
    .msb_first_i(cfg_msb_first),
    .valid_o    (rx_valid),
    .data_o     (rx_data),
    .perr_o     (rx_parity_err),
    .ferr_o     (rx_frame_err),
    .serr_o     (rx_start_err)
  );
endmodule

// File: tb/serial_rx_tb.sv
`timescale 1ns/1ps
module serial_rx_tb_top;
  localparam int CPB = 8;
  localparam int HALF = CPB / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b0;
  logic       cfg_invert = 1'b0;
  logic [15:0] cfg_clks_per_bit = 16'(CPB);
  logic [3:0] cfg_width = 4'd8;
  logic [2:0] cfg_parity = 3'd0;
  logic       cfg_msb_first = 1'b0;
  logic       rx_valid;
  logic [8:0] rx_data;
  logic       rx_parity_err, rx_frame_err, rx_start_err;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int nvalid = 0;
  int fall_cyc = 0;
  int cap_cyc = 0;
  int pulse_viol = 0;
  logic prev_valid = 1'b0;
  logic [8:0] cap_data;
  logic cap_perr, cap_ferr, cap_serr;

  always #4 clk = ~clk;

  serial_rx dut_i (
    .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_invert(cfg_invert),
    .cfg_clks_per_bit(cfg_clks_per_bit), .cfg_width(cfg_width),
    .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_start_err(rx_start_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      nvalid   <= nvalid + 1;
      cap_cyc  <= cyc;
      cap_data <= rx_data;
      cap_perr <= rx_parity_err;
      cap_ferr <= rx_frame_err;
      cap_serr <= rx_start_err;
      if (prev_valid) pulse_viol <= pulse_viol + 1;
    end
    prev_valid <= rx_valid;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int n);
    rx_line = b ^ cfg_invert;
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame using the current cfg inputs for width/parity/order.
  task automatic send_frame(input logic [8:0] d, input int w, input int pm,
                            input logic msb, input logic bad_par,
                            input logic glitch, input logic stopv);
    logic [8:0] mask;
    logic pbit;
    mask = 9'((1 << w) - 1);
    case (pm)
      1: pbit = ~(^(d & mask));
      2: pbit = ^(d & mask);
      3: pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
    pbit = pbit ^ bad_par;
    fall_cyc = cyc;
    if (glitch) begin
      drive(1'b0, 2);
      drive(1'b1, CPB - 2);
    end else begin
      drive(1'b0, CPB);
    end
    for (int i = 0; i < w; i++) drive(msb ? d[w-1-i] : d[i], CPB);
    if (pm != 0) drive(pbit, CPB);
    drive(stopv, CPB);
    if (!stopv) drive(1'b0, CPB);
    drive(1'b1, 3 * CPB);
  endtask

  task automatic run_and_check(input logic [8:0] d, input int w, input int pm,
                               input logic msb, input logic bad_par,
                               input logic glitch, input logic stopv,
                               input string dtag);
    int n0;
    int lat;
    n0 = nvalid;
    cfg_width = 4'(w);
    cfg_parity = 3'(pm);
    cfg_msb_first = msb;
    send_frame(d, w, pm, msb, bad_par, glitch, stopv);
    lat = 3 + HALF + (w + 1 + ((pm != 0) ? 1 : 0)) * CPB;
    check(nvalid == n0 + 1, "R11 one strobe", nvalid - n0, 1);
    check(cap_data == d, dtag, int'(cap_data), int'(d));
    check(cap_cyc - fall_cyc == lat, "R2 latency", cap_cyc - fall_cyc, lat);
    check(cap_perr == ((pm != 0) && bad_par),
          (pm == 0) ? "R7 perr" : ((pm <= 2) ? "R5 perr" : "R6 perr"),
          int'(cap_perr), int'((pm != 0) && bad_par));
    check(cap_ferr == !stopv, "R9 ferr", int'(cap_ferr), int'(!stopv));
    check(cap_serr == glitch, "R8 serr", int'(cap_serr), int'(glitch));
  endtask

  task automatic finish_run();
    check(pulse_viol == 0, "R11 pulse width", pulse_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] d;
    logic [8:0] mask;
    // R1: line low through and after reset
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(rx_valid == 1'b0, "R1 reset valid", int'(rx_valid), 0);
    repeat (100) @(negedge clk);
    check(nvalid == 0, "R1 low line no frame", nvalid, 0);
    drive(1'b1, 3 * CPB);
    check(nvalid == 0, "R1 idle high", nvalid, 0);

    // Sweep widths, parity modes, orders, data patterns, good/bad parity
    for (int w = 5; w <= 9; w++) begin
      mask = 9'((1 << w) - 1);
      for (int pm = 0; pm <= 4; pm++) begin
        for (int mo = 0; mo < 2; mo++) begin
          for (int v = 0; v < 4; v++) begin
            for (int bp = 0; bp < 2; bp++) begin
              if (pm == 0 && bp == 1) continue;
              case (v)
                0: d = 9'h000;
                1: d = mask;
                2: d = 9'(w * 29 + pm * 7 + mo * 3 + bp * 11) & mask;
                default: d = 9'h155 & mask;
              endcase
              run_and_check(d, w, pm, mo[0], bp[0], 1'b0, 1'b1,
                            (mo == 1) ? "R4 msb data" : "R3 lsb data");
            end
          end
        end
      end
    end

    // R8: glitched start bit, frame continues
    run_and_check(9'h0A5, 8, 2, 1'b0, 1'b0, 1'b1, 1'b1, "R8 data after bad start");
    // R9: missing stop bit, then a normal frame
    run_and_check(9'h03C, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 data with ferr");
    run_and_check(9'h0C3, 8, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 recovery data");

    // R10: inverted line
    @(negedge clk);
    cfg_invert = 1'b1;
    rx_line = 1'b0;
    repeat (3 * CPB) @(negedge clk);
    check(nvalid > 0 && cap_data == 9'h0C3, "R10 no spurious frame", int'(cap_data), 9'h0C3);
    run_and_check(9'h05A, 8, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R10 inverted data");
    run_and_check(9'h1B4, 9, 3, 1'b1, 1'b1, 1'b0, 1'b1, "R10 inverted msb data");
    @(negedge clk);
    cfg_invert = 1'b0;
    rx_line = 1'b1;
    repeat (3 * CPB) @(negedge clk);

    // R12: width changed mid-frame has no effect on the frame in progress
    begin
      int n0;
      n0 = nvalid;
      cfg_width = 4'd8;
      cfg_parity = 3'd0;
      cfg_msb_first = 1'b0;
      fork
        send_frame(9'h0E7, 8, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        begin
          repeat (6) @(negedge clk);
          cfg_width = 4'd5;
          cfg_msb_first = 1'b1;
        end
      join
      check(nvalid == n0 + 1, "R12 strobe count", nvalid - n0, 1);
      check(cap_data == 9'h0E7, "R12 latched width data", int'(cap_data), 9'h0E7);
      check(cap_cyc - fall_cyc == 3 + HALF + 9 * CPB, "R12 latched timing",
            cap_cyc - fall_cyc, 3 + HALF + 9 * CPB);
    end

    finish_run();
  end
endmodule